// File: doc/BRIEF.md
# Raster Frame Timing Generator with Vertical-Blank Interrupt

This block keeps track of where a video frame is being scanned. It counts dots within a line and lines within a frame, one dot per clock. It marks the active picture area and keeps a vertical-blank flag. From that flag it requests a non-maskable interrupt, so the processor can update picture data while nothing is being drawn. It also produces a processor clock enable that pulses on one dot clock out of every three.

The frame is 341 dots by 262 lines, and the active picture is the top-left 256 by 240 positions. The vertical-blank flag rises at dot 1 of line 241 and falls at dot 1 of line 261. Reading the status clears it earlier. The interrupt request is the flag gated by an enable bit, so turning the enable on during blanking raises the request at once. The external reset is asserted asynchronously and its release is synchronised inside the block.

Top module: `scan_timing_gen`

## Requirements
- R1: `dot_x` advances by one on every rising clock edge, counting 0 to 340, and wraps from 340 back to 0.
- R2: `line_y` advances by one on the edge where `dot_x` wraps and holds on every other edge; it counts 0 to 261 and wraps from 261 back to 0.
- R3: `visible` is high exactly when `dot_x` < 256 and `line_y` < 240.
- R4: `vblank` is high first in the cycle where the counters read line 241, dot 1. Without a status read it stays high until the cycle where the counters read line 261, dot 1, where it is low.
- R5: A `status_rd` that is high at a rising edge makes `vblank` low from the next cycle. The exception is the edge that enters line 241, dot 1: there the set takes priority. A status read outside vertical blank changes nothing.
- R6: `nmi` equals `vblank` AND `nmi_en` within the same cycle, without waiting for a clock edge. It is therefore never high while `visible` is high.
- R7: `cpu_ce` is high in one cycle out of every three. It is high in the first cycle in which the counters have left reset, and in every third cycle after it.
- R8: While `rst_n` is low, `dot_x` and `line_y` are 0 and `vblank` and `nmi` are low, starting at once, without a clock. After `rst_n` rises, the counters stay at 0 through two rising edges and first advance on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low reset; asynchronous assertion, synchronised release |
| nmi_en | input | 1 | Lets the vertical-blank flag through to `nmi` |
| status_rd | input | 1 | Single-cycle status read strobe; clears the vertical-blank flag |
| dot_x | output | 9 | Dot position within the current line |
| line_y | output | 9 | Line position within the current frame |
| visible | output | 1 | High inside the 256x240 active picture |
| vblank | output | 1 | Vertical-blank flag |
| nmi | output | 1 | Non-maskable interrupt request to the processor |
| cpu_ce | output | 1 | Processor clock enable, one dot clock in three |

## Verification
The assertions assume that `status_rd` and `nmi_en` change only between clock edges and are synchronous to `clk`. The only asynchronous input is the assertion of `rst_n`. The bench changes every input on the falling edge and releases reset there as well. It samples one nanosecond later, so each observation lies between two rising edges. The sweep covers one full frame and most of a second one. It toggles `nmi_en` every five cycles and places status reads at three points: outside blanking, in the middle of blanking, and on the edge that sets the flag. This exercises the read-versus-set priority and the immediate interrupt response.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Default frame geometry (dot clocks per line, lines per frame)
  localparam int unsigned DEF_LINE_DOTS   = 341;
  localparam int unsigned DEF_FRAME_LINES = 262;
  localparam int unsigned DEF_ACT_DOTS    = 256;
  localparam int unsigned DEF_ACT_LINES   = 240;
  localparam int unsigned DEF_BLANK_FIRST = 241;
  localparam int unsigned DEF_BLANK_LAST  = 261;
  localparam int unsigned DEF_EDGE_DOT    = 1;
  localparam int unsigned DEF_CE_RATIO    = 3;

  // Action taken on the blank flag at the coming edge
  typedef enum logic [1:0] {
    BLK_HOLD  = 2'd0,
    BLK_SET   = 2'd1,
    BLK_CLEAR = 2'd2
  } blank_evt_e;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/scan_dot_line_cnt.sv
module scan_dot_line_cnt #(
  parameter int unsigned LINE_DOTS   = 341,
  parameter int unsigned FRAME_LINES = 262,
  localparam int unsigned DW = $clog2(LINE_DOTS),
  localparam int unsigned LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q
);

  localparam logic [DW-1:0] DOT_LAST  = DW'(LINE_DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(FRAME_LINES - 1);

  logic          dot_wrap;
  logic [DW-1:0] dot_d;
  logic [LW-1:0] line_d;

  always_comb begin
    dot_wrap = (dot_q == DOT_LAST);
    dot_d    = dot_q + 1'b1;
    line_d   = line_q;
    if (dot_wrap) begin
      dot_d = '0;
      if (line_q == LINE_LAST) begin
        line_d = '0;
      end else begin
        line_d = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      dot_q  <= dot_d;
      line_q <= line_d;
    end
  end

  AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dot_q <= DOT_LAST); // R1
  AST_DOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q != DOT_LAST) |=> (dot_q == $past(dot_q) + 1'b1)); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q != DOT_LAST) |=> $stable(line_q)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q == DOT_LAST && line_q == LINE_LAST) |=> (dot_q == '0 && line_q == '0)); // R2
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LINE_LAST); // R2

endmodule

// File: rtl/scan_blank_ctrl.sv
module scan_blank_ctrl
  import scan_pkg::*;
#(
  parameter int unsigned LINE_DOTS   = 341,
  parameter int unsigned FRAME_LINES = 262,
  parameter int unsigned BLANK_FIRST = 241,
  parameter int unsigned BLANK_LAST  = 261,
  parameter int unsigned EDGE_DOT    = 1,
  localparam int unsigned DW = $clog2(LINE_DOTS),
  localparam int unsigned LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dot_q,
  input  logic [LW-1:0] line_q,
  input  logic          status_rd,
  input  logic          nmi_en,
  output logic          blank_q,
  output logic          nmi
);

  localparam logic [DW-1:0] PRE_DOT  = DW'(EDGE_DOT - 1);
  localparam logic [DW-1:0] EDGE_D   = DW'(EDGE_DOT);
  localparam logic [LW-1:0] L_FIRST  = LW'(BLANK_FIRST);
  localparam logic [LW-1:0] L_LAST   = LW'(BLANK_LAST);

  blank_evt_e evt;
  logic       at_set;
  logic       at_clr;
  logic       blank_d;

  always_comb begin
    at_set = (line_q == L_FIRST) && (dot_q == PRE_DOT);
    at_clr = (line_q == L_LAST)  && (dot_q == PRE_DOT);
    if (at_set) begin
      evt = BLK_SET;
    end else if (at_clr || status_rd) begin
      evt = BLK_CLEAR;
    end else begin
      evt = BLK_HOLD;
    end
  end

  always_comb begin
    unique case (evt)
      BLK_SET:   blank_d = 1'b1;
      BLK_CLEAR: blank_d = 1'b0;
      default:   blank_d = blank_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
    end else begin
      blank_q <= blank_d;
    end
  end

  assign nmi = blank_q & nmi_en;

  AST_BLANK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_q) |-> (line_q == L_FIRST && dot_q == EDGE_D)); // R4
  AST_BLANK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == L_LAST && dot_q == EDGE_D) |-> !blank_q); // R4
  AST_FIRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == L_FIRST && dot_q == EDGE_D) |-> blank_q); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(line_q == L_FIRST && dot_q == PRE_DOT)) |=> !blank_q); // R5

endmodule

// File: rtl/scan_ce_div.sv
module scan_ce_div #(
  parameter int unsigned CE_RATIO = 3,
  localparam int unsigned PW = (CE_RATIO > 1) ? $clog2(CE_RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);

  localparam logic [PW-1:0] PH_LAST = PW'(CE_RATIO - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  always_comb begin
    if (phase_q == PH_LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign ce = (phase_q == '0);

  generate
    if (CE_RATIO > 1) begin : g_gap_chk
      AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> !ce); // R7
    end
  endgenerate

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_pkg::*;
#(
  parameter int unsigned LINE_DOTS   = DEF_LINE_DOTS,
  parameter int unsigned FRAME_LINES = DEF_FRAME_LINES,
  parameter int unsigned ACT_DOTS    = DEF_ACT_DOTS,
  parameter int unsigned ACT_LINES   = DEF_ACT_LINES,
  parameter int unsigned BLANK_FIRST = DEF_BLANK_FIRST,
  parameter int unsigned BLANK_LAST  = DEF_BLANK_LAST,
  parameter int unsigned EDGE_DOT    = DEF_EDGE_DOT,
  parameter int unsigned CE_RATIO    = DEF_CE_RATIO,
  localparam int unsigned DW = $clog2(LINE_DOTS),
  localparam int unsigned LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_en,
  input  logic          status_rd,
  output logic [DW-1:0] dot_x,
  output logic [LW-1:0] line_y,
  output logic          visible,
  output logic          vblank,
  output logic          nmi,
  output logic          cpu_ce
);

  localparam logic [DW-1:0] ACT_D = DW'(ACT_DOTS);
  localparam logic [LW-1:0] ACT_L = LW'(ACT_LINES);

  logic rst_i_n;

  scan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  scan_dot_line_cnt #(
    .LINE_DOTS   (LINE_DOTS),
    .FRAME_LINES (FRAME_LINES)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .dot_q  (dot_x),
    .line_q (line_y)
  );

  scan_blank_ctrl #(
    .LINE_DOTS   (LINE_DOTS),
    .FRAME_LINES (FRAME_LINES),
    .BLANK_FIRST (BLANK_FIRST),
    .BLANK_LAST  (BLANK_LAST),
    .EDGE_DOT    (EDGE_DOT)
  ) u_blank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .dot_q     (dot_x),
    .line_q    (line_y),
    .status_rd (status_rd),
    .nmi_en    (nmi_en),
    .blank_q   (vblank),
    .nmi       (nmi)
  );

  scan_ce_div #(
    .CE_RATIO (CE_RATIO)
  ) u_ce (
    .clk   (clk),
    .rst_n (rst_i_n),
    .ce    (cpu_ce)
  );

  always_comb begin
    visible = (dot_x < ACT_D) && (line_y < ACT_L);
  end

  AST_NMI_OFF_SCREEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    visible |-> !nmi); // R6
  AST_BLANK_OFF_SCREEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    visible |-> !vblank); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (dot_x == '0 && line_y == '0 && !vblank && !nmi)); // R8

endmodule

// File: tb/test_scan_timing_gen.sv
module test_scan_timing_gen;

  localparam int DOTS  = 341;
  localparam int LINES = 262;
  localparam int FRAME = DOTS * LINES;
  localparam int RD_IDLE = DOTS * 120 + 5;
  localparam int RD_SET  = DOTS * 241;
  localparam int RD_MID  = DOTS * 250 + 20;
  localparam int LAST_N  = FRAME + DOTS * 245;

  logic       clk;
  logic       rst_n;
  logic       nmi_en;
  logic       status_rd;
  logic [8:0] dot_x;
  logic [8:0] line_y;
  logic       visible;
  logic       vblank;
  logic       nmi;
  logic       cpu_ce;

  int checks;
  int fails;
  int exp_vbl;

  scan_timing_gen i_scan_timing_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_en    (nmi_en),
    .status_rd (status_rd),
    .dot_x     (dot_x),
    .line_y    (line_y),
    .visible   (visible),
    .vblank    (vblank),
    .nmi       (nmi),
    .cpu_ce    (cpu_ce)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(10 * 199000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    nmi_en = 1'b1;
    status_rd = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "reset dot", int'(dot_x), 0);
    chk("R8", "reset line", int'(line_y), 0);
    chk("R8", "reset vblank", int'(vblank), 0);
    chk("R8", "reset nmi", int'(nmi), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_vbl = 0;

    for (int n = 0; n <= LAST_N; n++) begin
      int d;
      int l;
      int pd;
      int pl;
      logic rd;
      d = n % DOTS;
      l = (n / DOTS) % LINES;
      status_rd = 1'b0;
      nmi_en = ((n / 5) % 2) == 1;
      #1;
      chk("R1", "dot_x", int'(dot_x), d);
      chk("R2", "line_y", int'(line_y), l);
      chk("R3", "visible", int'(visible), int'(d < 256 && l < 240));
      chk("R4/R5", "vblank", int'(vblank), exp_vbl);
      chk("R6", "nmi", int'(nmi), exp_vbl & int'(nmi_en));
      chk("R7", "cpu_ce", int'(cpu_ce), int'((n % 3) == 0));
      rd = (n == RD_IDLE) || (n == RD_SET) || (n == RD_MID);
      status_rd = rd;
      @(posedge clk);
      @(negedge clk);
      pd = (n + 1) % DOTS;
      pl = ((n + 1) / DOTS) % LINES;
      if (pl == 241 && pd == 1) exp_vbl = 1;
      else if (pl == 261 && pd == 1) exp_vbl = 0;
      else if (rd) exp_vbl = 0;
    end

    status_rd = 1'b0;
    nmi_en = 1'b1;
    #1;
    chk("R6", "nmi after enable in blank", int'(nmi), 1);
    rst_n = 1'b0;
    #1;
    chk("R8", "async reset dot", int'(dot_x), 0);
    chk("R8", "async reset line", int'(line_y), 0);
    chk("R8", "async reset vblank", int'(vblank), 0);
    chk("R8", "async reset nmi", int'(nmi), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8", "hold after release edge 1", int'(dot_x), 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8", "hold after release edge 2", int'(dot_x), 0);
    chk("R7", "ce after release", int'(cpu_ce), 1);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8", "advance on edge 3", int'(dot_x), 1);
    chk("R7", "ce low next", int'(cpu_ce), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule